// File: doc/BRIEF.md
# DRAM Self-Refresh Sleep/Wake Sequencer

This block sits on the controller side of a DDR2-style DRAM channel. It moves the memory into self-refresh and later brings it back. A sleep request makes the sequencer take the command bus away from the normal controller. It drives one self-refresh command with the clock enable low, then keeps the memory clock running for one more cycle. Only after that cycle does it tell the clock logic that the memory clock may be gated, and it acknowledges the sleep.

A wake request withdraws the gating hint. The sequencer then waits until the clock-stable input has been seen high on two consecutive edges and raises the clock enable. It then drives only no-operation commands for an exit window whose length is a parameter, 200 cycles by default. Once the window has counted down, it hands the bus back to the controller and pulses a wake acknowledge. A wake request that arrives while entry is still in progress is remembered and served as soon as the sleep state is reached. Entry is never cut short.

Top module: `dram_selfrefresh_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, cke=1, bus_grant=1, {cs_n,ras_n,cas_n,we_n}=4'b1111 (deselect), and clk_gate_ok, sleep_ack and wake_ack are all 0.
- R2: When sleep_req is sampled high while the bus is granted, the next cycle carries exactly one self-refresh command {cs_n,ras_n,cas_n,we_n}=4'b0001 with cke=0 and bus_grant=0.
- R3: The cycle after the self-refresh command keeps cke=0 with deselect and clk_gate_ok=0. From the following cycle on, the sleep state holds cke=0, deselect, clk_gate_ok=1 and sleep_ack=1.
- R4: After a wake request is accepted, clk_gate_ok and sleep_ack are 0 from the next cycle. cke stays 0 (deselect) until clk_stable has been sampled high on two consecutive rising edges. cke rises in the cycle after the second such edge. If clk_stable drops after a single high sample, the two-edge count starts again.
- R5: clk_gate_ok is never 1 while cke is 1. It is 0 in the cycle before cke rises.
- R6: After cke rises, cke stays 1 and bus_grant stays 0 for exactly max(EXIT_CYCLES, CKE_MIN) cycles, 200 by default. In each of these cycles the command is NOP {cs_n,ras_n,cas_n,we_n}=4'b0111.
- R7: In the first cycle after the exit window, bus_grant=1 and wake_ack=1. wake_ack is 0 again in the cycle after that.
- R8: A wake_req sampled during the self-refresh command cycle or during the stable-clock cycle that follows it is held. The sleep state then lasts one cycle before the wake path of R4 starts.
- R9: bus_grant is 0 from the cycle after sleep_req is sampled until the exit window ends. While bus_grant is 1, the sequencer drives cke=1 and deselect.
- R10: wake_req has no effect while the bus is granted. sleep_req has no effect once a sequence is under way: the exit window length of R6 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to put the memory into self-refresh |
| wake_req | input | 1 | Request to bring the memory out of self-refresh |
| clk_stable | input | 1 | Memory clock is running and within specification |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| bus_grant | output | 1 | Normal controller may drive the command bus |
| sleep_ack | output | 1 | Memory is in self-refresh |
| wake_ack | output | 1 | One-cycle pulse: exit complete, bus returned |
| clk_gate_ok | output | 1 | Hint that the memory clock may be stopped |

## Verification
The hardest situations to reach from the ports are a wake request that lands inside the two-cycle entry sequence, and a clock-stable signal that drops again right after its first high sample. In both cases the sequencer must hold state or restart a count instead of moving on. The bench sweeps the cycle at which the wake request arrives, from the self-refresh command cycle up to several cycles into sleep. It also sweeps how long clock-stable stays low. One variant deliberately drops clock-stable in the confirmation cycle, and another toggles sleep and wake in the middle of the exit window.

// File: rtl/slpseq_pkg.sv
package slpseq_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_ENTER   = 3'd1,
    ST_HOLD    = 3'd2,
    ST_SLEEP   = 3'd3,
    ST_WAKECLK = 3'd4,
    ST_WAKESTB = 3'd5,
    ST_EXIT    = 3'd6
  } sr_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dram_cmd_t;

  function automatic dram_cmd_t cmd_selfref();
    dram_cmd_t c;
    c = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    return c;
  endfunction

  function automatic dram_cmd_t cmd_nop();
    dram_cmd_t c;
    c = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    return c;
  endfunction

  function automatic dram_cmd_t cmd_deselect();
    dram_cmd_t c;
    c = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    return c;
  endfunction

  // Length of the exit window: the longer of the programmed interval
  // and the minimum clock-enable high time.
  function automatic int exit_len(input int cycles, input int cke_min);
    return (cycles > cke_min) ? cycles : cke_min;
  endfunction

  // Value loaded into the down-counter on entry to the exit window.
  function automatic int exit_load(input int cycles, input int cke_min);
    return exit_len(cycles, cke_min) - 1;
  endfunction

  function automatic int cnt_width(input int load);
    return (load < 2) ? 1 : $clog2(load + 1);
  endfunction

endpackage

// File: rtl/slpseq_exit_cnt.sv
module slpseq_exit_cnt #(
  parameter int CNT_W = 8,
  parameter int LOAD  = 199
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic cnt_zero
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_V;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/slpseq_fsm.sv
module slpseq_fsm
  import slpseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      wake_req,
  input  logic      clk_stable,
  input  logic      cnt_zero,
  output sr_state_e state,
  output logic      ev_load,
  output logic      ev_exit_done,
  output logic      ack_q
);
  sr_state_e state_q, state_d;
  logic      pend_q;
  logic      wake_go;
  logic      in_entry;

  assign in_entry     = (state_q == ST_ENTER) || (state_q == ST_HOLD);
  assign wake_go      = wake_req || pend_q;
  assign ev_load      = (state_q == ST_WAKESTB) && clk_stable;
  assign ev_exit_done = (state_q == ST_EXIT) && cnt_zero;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (sleep_req) state_d = ST_ENTER;
      ST_ENTER:   state_d = ST_HOLD;
      ST_HOLD:    state_d = ST_SLEEP;
      ST_SLEEP:   if (wake_go) state_d = ST_WAKECLK;
      ST_WAKECLK: if (clk_stable) state_d = ST_WAKESTB;
      ST_WAKESTB: state_d = clk_stable ? ST_EXIT : ST_WAKECLK;
      ST_EXIT:    if (cnt_zero) state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ev_exit_done;
      if (state_q == ST_SLEEP) begin
        pend_q <= 1'b0;
      end else if (in_entry && wake_req) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign state = state_q;
endmodule

// File: rtl/slpseq_cmd.sv
module slpseq_cmd
  import slpseq_pkg::*;
#(
  parameter bit EXIT_NOP = 1'b1
) (
  input  sr_state_e state,
  output dram_cmd_t cmd,
  output logic      cke,
  output logic      grant,
  output logic      gate_ok,
  output logic      sleep_ack
);
  dram_cmd_t exit_cmd;

  generate
    if (EXIT_NOP) begin : g_exit_nop
      assign exit_cmd = cmd_nop();
    end else begin : g_exit_desel
      assign exit_cmd = cmd_deselect();
    end
  endgenerate

  always_comb begin
    cmd       = cmd_deselect();
    cke       = 1'b0;
    grant     = 1'b0;
    gate_ok   = 1'b0;
    sleep_ack = 1'b0;
    unique case (state)
      ST_RUN: begin
        cke   = 1'b1;
        grant = 1'b1;
      end
      ST_ENTER: cmd = cmd_selfref();
      ST_SLEEP: begin
        gate_ok   = 1'b1;
        sleep_ack = 1'b1;
      end
      ST_EXIT: begin
        cke = 1'b1;
        cmd = exit_cmd;
      end
      default: cmd = cmd_deselect();
    endcase
  end
endmodule

// File: rtl/dram_selfrefresh_seq.sv
module dram_selfrefresh_seq
  import slpseq_pkg::*;
#(
  parameter int EXIT_CYCLES = 200,
  parameter int CKE_MIN     = 3,
  parameter bit EXIT_NOP    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic clk_stable,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic bus_grant,
  output logic sleep_ack,
  output logic wake_ack,
  output logic clk_gate_ok
);
  localparam int LOAD_V = exit_load(EXIT_CYCLES, CKE_MIN);
  localparam int CNT_W  = cnt_width(LOAD_V);

  sr_state_e state;
  dram_cmd_t cmd;
  logic      ev_load;
  logic      ev_exit_done;
  logic      cnt_zero;
  logic      in_exit;

  assign in_exit = (state == ST_EXIT);

  slpseq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .wake_req     (wake_req),
    .clk_stable   (clk_stable),
    .cnt_zero     (cnt_zero),
    .state        (state),
    .ev_load      (ev_load),
    .ev_exit_done (ev_exit_done),
    .ack_q        (wake_ack)
  );

  slpseq_exit_cnt #(
    .CNT_W (CNT_W),
    .LOAD  (LOAD_V)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_load),
    .run      (in_exit),
    .cnt_zero (cnt_zero)
  );

  slpseq_cmd #(
    .EXIT_NOP (EXIT_NOP)
  ) u_cmd (
    .state     (state),
    .cmd       (cmd),
    .cke       (cke),
    .grant     (bus_grant),
    .gate_ok   (clk_gate_ok),
    .sleep_ack (sleep_ack)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
endmodule

// File: rtl/slpseq_checker.sv
module slpseq_checker
  import slpseq_pkg::*;
#(
  parameter int EXIT_CYCLES = 200,
  parameter int CKE_MIN     = 3
) (
  input logic clk,
  input logic rst_n,
  input logic clk_stable,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic bus_grant,
  input logic sleep_ack,
  input logic wake_ack,
  input logic clk_gate_ok,
  input logic ev_exit_done
);
  localparam int EXP_LEN = exit_len(EXIT_CYCLES, CKE_MIN);

  logic [3:0] cmd_v;
  int         win_cnt;

  assign cmd_v = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= 0;
    end else if (cke && !bus_grant) begin
      win_cnt <= win_cnt + 1;
    end else begin
      win_cnt <= 0;
    end
  end

  AST_SR_WITH_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_v == 4'b0001) |-> (!cke && !bus_grant)); // R2

  AST_SLEEP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> (!cke && clk_gate_ok && cs_n)); // R3

  AST_GATE_AFTER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_ok) |-> ($past(cmd_v) == 4'b1111 && !$past(cke))); // R3

  AST_CKE_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ($past(clk_stable) && $past(clk_stable, 2))); // R4

  AST_GATE_NOT_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_ok |-> !cke); // R5

  AST_GATE_OFF_BEFORE_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> !$past(clk_gate_ok)); // R5

  AST_EXIT_NOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !bus_grant) |-> (cmd_v == 4'b0111)); // R6

  AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ($past(cke, 2) && $past(cke, 3))); // R6

  AST_EXIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exit_done |-> (win_cnt == EXP_LEN - 1)); // R6

  AST_WAKE_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |=> !wake_ack); // R7

  AST_WAKE_ACK_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |-> (bus_grant && !$past(bus_grant))); // R7

  AST_GRANT_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (cke && cmd_v == 4'b1111 && !clk_gate_ok)); // R9
endmodule

bind dram_selfrefresh_seq slpseq_checker #(
  .EXIT_CYCLES (EXIT_CYCLES),
  .CKE_MIN     (CKE_MIN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clk_stable   (clk_stable),
  .cke          (cke),
  .cs_n         (cs_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .bus_grant    (bus_grant),
  .sleep_ack    (sleep_ack),
  .wake_ack     (wake_ack),
  .clk_gate_ok  (clk_gate_ok),
  .ev_exit_done (ev_exit_done)
);

// File: tb/dram_selfrefresh_seq_test.sv
module dram_selfrefresh_seq_test;
  localparam int EXIT_N = 200;

  // {cke, cs_n, ras_n, cas_n, we_n, bus_grant, clk_gate_ok, sleep_ack}
  localparam logic [7:0] P_RUN   = 8'b1_1111_1_0_0;
  localparam logic [7:0] P_SR    = 8'b0_0001_0_0_0;
  localparam logic [7:0] P_LOW   = 8'b0_1111_0_0_0;
  localparam logic [7:0] P_SLEEP = 8'b0_1111_0_1_1;
  localparam logic [7:0] P_EXIT  = 8'b1_0111_0_0_0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0;
  logic wake_req = 1'b0;
  logic clk_stable = 1'b1;
  logic cke, cs_n, ras_n, cas_n, we_n, bus_grant, sleep_ack, wake_ack, clk_gate_ok;
  logic [7:0] obs;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_selfrefresh_seq uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .wake_req    (wake_req),
    .clk_stable  (clk_stable),
    .cke         (cke),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .bus_grant   (bus_grant),
    .sleep_ack   (sleep_ack),
    .wake_ack    (wake_ack),
    .clk_gate_ok (clk_gate_ok)
  );

  assign obs = {cke, cs_n, ras_n, cas_n, we_n, bus_grant, clk_gate_ok, sleep_ack};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // One full sleep/wake sequence.
  // wd: 0 = wake in SR cycle, 1 = wake in stable cycle, >=2 = wd-2 extra sleep cycles.
  // sd: extra cycles clk_stable stays low after wake. glitch: drop stable once.
  // poke: toggle sleep_req/wake_req in the middle of the exit window.
  task automatic run_seq(input int wd, input int sd, input bit glitch, input bit poke);
    int n;
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
    chk("R2 self-refresh command cycle", obs, P_SR);
    chk("R9 grant dropped", bus_grant, 0);
    if (wd == 0) wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R3 stable-clock cycle", obs, P_LOW);
    if (wd == 1) wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R3 sleep state", obs, P_SLEEP);
    clk_stable = 1'b0;
    if (wd >= 2) begin
      for (int i = 0; i < wd - 2; i++) begin
        step();
        chk("R3 sleep held", obs, P_SLEEP);
      end
      wake_req = 1'b1;
      step();
      wake_req = 1'b0;
      chk("R4 gate hint withdrawn", obs, P_LOW);
    end else begin
      step();
      chk("R8 held wake served after one sleep cycle", obs, P_LOW);
    end
    for (int i = 0; i < sd; i++) begin
      step();
      chk("R4 waiting for stable clock", obs, P_LOW);
    end
    clk_stable = 1'b1;
    step();
    chk("R4 one stable sample, cke still low", obs, P_LOW);
    if (glitch) begin
      clk_stable = 1'b0;
      step();
      chk("R4 glitch restarts wait", obs, P_LOW);
      clk_stable = 1'b1;
      step();
      chk("R4 stable again, first sample", obs, P_LOW);
    end
    step();
    chk("R5 cke high with gate hint off", obs, P_EXIT);
    n = 1;
    for (int i = 0; i < 1000; i++) begin
      if (poke && n == 50) begin
        sleep_req = 1'b1;
        wake_req  = 1'b1;
      end else begin
        sleep_req = 1'b0;
        wake_req  = 1'b0;
      end
      step();
      if (obs != P_EXIT) break;
      n++;
    end
    sleep_req = 1'b0;
    wake_req  = 1'b0;
    chk(poke ? "R10 exit length unchanged by requests" : "R6 exit window length", n, EXIT_N);
    chk("R7 bus returned", obs, P_RUN);
    chk("R7 wake_ack pulse", wake_ack, 1);
    step();
    chk("R7 wake_ack single cycle", wake_ack, 0);
    chk("R9 bus stays granted", obs, P_RUN);
  endtask

  initial begin
    repeat (5) step();
    chk("R1 reset outputs", obs, P_RUN);
    chk("R1 reset wake_ack", wake_ack, 0);
    rst_n = 1'b1;
    step();
    chk("R1 first cycle after reset", obs, P_RUN);
    wake_req = 1'b1;
    repeat (3) begin
      step();
      chk("R10 wake_req ignored while granted", obs, P_RUN);
    end
    wake_req = 1'b0;
    step();
    chk("R10 still granted after stray wake", obs, P_RUN);
    for (int wd = 0; wd < 5; wd++) begin
      for (int sd = 0; sd < 3; sd++) begin
        run_seq(wd, sd, (sd == 2), (wd == 3 && sd == 1));
      end
    end
    run_seq(2, 0, 1'b1, 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule